// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This block handles parity on a 32-bit data bus that carries one parity bit per byte. On a write it drives four parity bits computed from the outgoing data. On a read it compares the returned parity bits against the data, byte by byte. The memory bank selected for the access supplies two attributes: whether parity is in use for that bank, and whether that bank uses odd or even parity. The bank number itself comes from an external decoder.

A read that fails its check in any enabled byte lane raises a one-cycle transfer-error acknowledge. It also sets a sticky error bit that belongs to the bank that was accessed. The error bits drive a level interrupt request. Software clears them with a write-1-to-clear strobe.

Top module: `byte_parity_unit`

## Requirements
- R1: Byte lane i (i = 0..3) is data bits [31-8i : 24-8i], so lane 0 is the most significant byte. Lane i pairs with `par_in[i]` and `par_out[i]`.
- R2: While `xfer_write`=1 and `bank_par_en`=1, `par_out[i]` is the XOR of lane i's bits when `bank_par_odd`=0 (even parity), and the inverse of that XOR when `bank_par_odd`=1 (odd parity). The output follows the inputs in the same cycle.
- R3: `par_out` is 4'b0000 whenever `bank_par_en`=0 or `xfer_write`=0.
- R4: A read is checked when `xfer_valid`=1, `xfer_write`=0 and `bank_par_en`=1. If any enabled lane has `par_in[i]` different from the expected parity (same rule as R2), bit `bank_id` of `err_flags` is 1 after the next rising edge.
- R5: A lane whose `lane_en[i]`=0 never causes an error, whatever its data and parity.
- R6: No error is recorded in three cases: when `bank_par_en`=0, on writes, and in cycles with `xfer_valid`=0.
- R7: `tea_pulse` is high for exactly the one cycle that follows each failing read cycle, and low after a passing or unchecked cycle.
- R8: Error bits are sticky. When `clr_wr`=1, each bit with `clr_mask[b]`=1 is cleared at the next edge, and bits with a mask of 0 keep their value.
- R9: If a clear and a new error hit the same bank bit in the same cycle, the bit ends up set.
- R10: `irq` is 1 exactly when at least one `err_flags` bit is 1.
- R11: A synchronous reset (`rst`=1) clears every error bit and drives `tea_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Data-valid strobe for the current transfer |
| xfer_write | input | 1 | 1 = write transfer, 0 = read transfer |
| bank_id | input | 3 | Number of the selected bank |
| bank_par_en | input | 1 | Parity in use for the selected bank |
| bank_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| lane_en | input | 4 | Per-lane byte enables, bit i for lane i |
| data_word | input | 32 | Data on the bus |
| par_in | input | 4 | Parity bits returned on a read, bit i for lane i |
| par_out | output | 4 | Parity bits generated for a write, bit i for lane i |
| clr_wr | input | 1 | Clear strobe for the error bits |
| clr_mask | input | 8 | Write-1-to-clear mask, one bit per bank |
| err_flags | output | 8 | Sticky per-bank parity error bits |
| irq | output | 1 | Interrupt request, high while any error bit is set |
| tea_pulse | output | 1 | One-cycle transfer-error acknowledge |

## Verification
Some properties are checked by assertions on every cycle:
- the generated parity bits always make each byte agree with the bank's polarity;
- writes, and reads with all lanes disabled, never raise an acknowledge;
- each acknowledge comes with the matching bank bit and the interrupt;
- an error bit never rises without a failing read;
- an error bit never survives a clear when no error hit it.

Other behaviours only the directed scenarios can show:
- the lane-to-bit mapping;
- that a deliberately corrupted lane is actually detected under each polarity;
- that a masked lane is really ignored;
- selective clearing across several banks;
- set winning over clear.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_pol_e;

    typedef struct packed {
        logic     en;
        par_pol_e pol;
        logic     wr;
    } bank_attr_t;

    // parity bit that gives a byte plus its parity the chosen polarity
    function automatic logic lane_par(input logic [BYTE_W-1:0] b, input par_pol_e pol);
        return (^b) ^ (pol == PAR_ODD);
    endfunction

endpackage

// File: rtl/bpar_gen.sv
module bpar_gen
    import bpar_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_attr_t        attr,
    input  logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  par
);

    logic active;
    assign active = attr.en && attr.wr;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] lane_byte;
        assign lane_byte = data[DATA_W-1-i*BYTE_W -: BYTE_W];
        assign par[i]    = active ? lane_par(lane_byte, attr.pol) : 1'b0;

        // R2
        gen_parity_chk: assert property (@(posedge clk) disable iff (rst)
            active |-> ((^{lane_byte, par[i]}) == (attr.pol == PAR_ODD)));
    end

endmodule

// File: rtl/bpar_chk.sv
module bpar_chk
    import bpar_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / BYTE_W
) (
    input  bank_attr_t        attr,
    input  logic              valid,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  par_in,
    output logic              fire
);

    logic             check_on;
    logic [LANES-1:0] lane_bad;

    assign check_on = valid && attr.en && !attr.wr;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic expect_bit;
        assign expect_bit  = lane_par(data[DATA_W-1-i*BYTE_W -: BYTE_W], attr.pol);
        assign lane_bad[i] = check_on && lane_en[i] && (expect_bit != par_in[i]);
    end

    assign fire = |lane_bad;

endmodule

// File: rtl/bpar_status.sv
module bpar_status #(
    parameter int N_BANKS = 8,
    parameter int BANK_W  = $clog2(N_BANKS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [BANK_W-1:0]  bank,
    input  logic               clr_wr,
    input  logic [N_BANKS-1:0] clr_mask,
    output logic [N_BANKS-1:0] flags,
    output logic               irq,
    output logic               tea
);

    logic [N_BANKS-1:0] set_vec;
    logic [N_BANKS-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        if (fire) set_vec[bank] = 1'b1;
        clr_vec = clr_wr ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            tea   <= 1'b0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
            tea   <= fire;
        end
    end

    assign irq = |flags;

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~$past(flags)) != '0) |-> $past(fire));

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (flags & $past(clr_vec & ~set_vec)) == '0);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> flags[$past(bank)]);

endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
    import bpar_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_BANKS = 8,
    parameter int LANES   = DATA_W / BYTE_W,
    parameter int BANK_W  = $clog2(N_BANKS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               xfer_valid,
    input  logic               xfer_write,
    input  logic [BANK_W-1:0]  bank_id,
    input  logic               bank_par_en,
    input  logic               bank_par_odd,
    input  logic [LANES-1:0]   lane_en,
    input  logic [DATA_W-1:0]  data_word,
    input  logic [LANES-1:0]   par_in,
    output logic [LANES-1:0]   par_out,
    input  logic               clr_wr,
    input  logic [N_BANKS-1:0] clr_mask,
    output logic [N_BANKS-1:0] err_flags,
    output logic               irq,
    output logic               tea_pulse
);

    bank_attr_t attr;
    logic       fire;

    always_comb begin
        attr.en  = bank_par_en;
        attr.pol = par_pol_e'(bank_par_odd);
        attr.wr  = xfer_write;
    end

    bpar_gen #(.DATA_W(DATA_W), .LANES(LANES)) u_gen (
        .clk  (clk),
        .rst  (rst),
        .attr (attr),
        .data (data_word),
        .par  (par_out)
    );

    bpar_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
        .attr    (attr),
        .valid   (xfer_valid),
        .lane_en (lane_en),
        .data    (data_word),
        .par_in  (par_in),
        .fire    (fire)
    );

    bpar_status #(.N_BANKS(N_BANKS), .BANK_W(BANK_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .bank     (bank_id),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .flags    (err_flags),
        .irq      (irq),
        .tea      (tea_pulse)
    );

    // R6
    no_tea_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && xfer_write) |=> !tea_pulse);

    // R5
    no_tea_no_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && lane_en == '0) |=> !tea_pulse);

    // R7
    tea_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
        tea_pulse |-> (err_flags[$past(bank_id)] && irq));

    // R3
    gen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(bank_par_en && xfer_write) |-> (par_out == '0));

endmodule

// File: tb/byte_parity_unit_tb.sv
`timescale 1ns/1ps
module byte_parity_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_valid = 1'b0;
    logic        xfer_write = 1'b0;
    logic [2:0]  bank_id = '0;
    logic        bank_par_en = 1'b0;
    logic        bank_par_odd = 1'b0;
    logic [3:0]  lane_en = '0;
    logic [31:0] data_word = '0;
    logic [3:0]  par_in = '0;
    logic [3:0]  par_out;
    logic        clr_wr = 1'b0;
    logic [7:0]  clr_mask = '0;
    logic [7:0]  err_flags;
    logic        irq;
    logic        tea_pulse;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    byte_parity_unit u_dut (
        .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
        .bank_id(bank_id), .bank_par_en(bank_par_en), .bank_par_odd(bank_par_odd),
        .lane_en(lane_en), .data_word(data_word), .par_in(par_in), .par_out(par_out),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .err_flags(err_flags), .irq(irq),
        .tea_pulse(tea_pulse)
    );

    function automatic logic [3:0] ref_par(input logic [31:0] d, input logic odd);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = (^d[31-8*i -: 8]) ^ odd;
        return p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_cycle(input logic [2:0] b, input logic en, input logic odd,
                              input logic [3:0] le, input logic [31:0] d, input logic [3:0] p);
        @(negedge clk);
        bank_id = b; bank_par_en = en; bank_par_odd = odd;
        lane_en = le; data_word = d; par_in = p;
        xfer_write = 1'b0; xfer_valid = 1'b1;
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic clear(input logic [7:0] m);
        @(negedge clk);
        clr_wr = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic t_reset();
        check("R11 flags", err_flags, 8'h00);
        check("R11 tea", tea_pulse, 1'b0);
        check("R10 irq", irq, 1'b0);
    endtask

    task automatic t_generate();
        @(negedge clk);
        xfer_write = 1'b1; bank_par_en = 1'b1; bank_par_odd = 1'b0;
        data_word = 32'h0100_0000;
        #1 check("R1 lane0 even", par_out, 4'b0001);
        data_word = 32'h0000_0007;
        #1 check("R1 lane3 even", par_out, 4'b1000);
        data_word = 32'h0103_FF80;
        #1 check("R2 even", par_out, ref_par(32'h0103_FF80, 1'b0));
        bank_par_odd = 1'b1;
        #1 check("R2 odd", par_out, ref_par(32'h0103_FF80, 1'b1));
        data_word = 32'hA5C3_0F11;
        #1 check("R2 odd b", par_out, ref_par(32'hA5C3_0F11, 1'b1));
        bank_par_en = 1'b0;
        #1 check("R3 disabled", par_out, 4'b0000);
        bank_par_en = 1'b1; xfer_write = 1'b0;
        #1 check("R3 read", par_out, 4'b0000);
    endtask

    task automatic t_read_good();
        read_cycle(3'd1, 1'b1, 1'b0, 4'hF, 32'h1234_5678, ref_par(32'h1234_5678, 1'b0));
        check("R4 good read tea", tea_pulse, 1'b0);
        check("R4 good read flags", err_flags, 8'h00);
    endtask

    task automatic t_read_bad();
        read_cycle(3'd2, 1'b1, 1'b0, 4'hF, 32'hDEAD_BEEF,
                   ref_par(32'hDEAD_BEEF, 1'b0) ^ 4'b0001);
        check("R7 tea high", tea_pulse, 1'b1);
        check("R4 bank2 flag", err_flags, 8'h04);
        check("R10 irq set", irq, 1'b1);
        @(negedge clk);
        check("R7 tea one cycle", tea_pulse, 1'b0);
        check("R8 sticky", err_flags, 8'h04);
        read_cycle(3'd6, 1'b1, 1'b1, 4'hF, 32'h0F0F_0F0F,
                   ref_par(32'h0F0F_0F0F, 1'b1) ^ 4'b1000);
        check("R4 odd lane3 flag", err_flags, 8'h44);
    endtask

    task automatic t_lane_mask();
        read_cycle(3'd5, 1'b1, 1'b0, 4'b0111, 32'h55AA_33CC,
                   ref_par(32'h55AA_33CC, 1'b0) ^ 4'b1000);
        check("R5 masked tea", tea_pulse, 1'b0);
        check("R5 masked flags", err_flags, 8'h44);
    endtask

    task automatic t_ignored();
        read_cycle(3'd0, 1'b0, 1'b0, 4'hF, 32'h8000_0001, 4'hF);
        check("R6 disabled bank", err_flags, 8'h44);
        @(negedge clk);
        bank_id = 3'd0; bank_par_en = 1'b1; lane_en = 4'hF; par_in = 4'hF;
        data_word = 32'h0; xfer_write = 1'b0; xfer_valid = 1'b0;
        @(negedge clk);
        check("R6 no strobe", err_flags, 8'h44);
        xfer_write = 1'b1; xfer_valid = 1'b1;
        @(negedge clk);
        xfer_valid = 1'b0; xfer_write = 1'b0;
        check("R6 write", err_flags, 8'h44);
        check("R6 write tea", tea_pulse, 1'b0);
    endtask

    task automatic t_clear();
        clear(8'h04);
        check("R8 selective clear", err_flags, 8'h40);
        check("R10 irq still", irq, 1'b1);
        clear(8'h00);
        check("R8 zero mask", err_flags, 8'h40);
        clear(8'h40);
        check("R8 cleared", err_flags, 8'h00);
        check("R10 irq off", irq, 1'b0);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        bank_id = 3'd3; bank_par_en = 1'b1; bank_par_odd = 1'b0; lane_en = 4'hF;
        data_word = 32'h0000_0001; par_in = 4'b0000;
        xfer_write = 1'b0; xfer_valid = 1'b1;
        clr_wr = 1'b1; clr_mask = 8'hFF;
        @(negedge clk);
        xfer_valid = 1'b0; clr_wr = 1'b0; clr_mask = '0;
        check("R9 set wins", err_flags, 8'h08);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 mid reset", err_flags, 8'h00);
        check("R11 mid tea", tea_pulse, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_generate();
        t_read_good();
        t_read_bad();
        t_lane_mask();
        t_ignored();
        t_clear();
        t_set_wins();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule